// File: doc/BRIEF.md
# Embedded Sync Code Inserter

This block turns an 8-bit multiplexed YCbCr pixel stream that comes with separate timing signals into a stream with embedded timing reference codes. It uses the BT.656 layout. Around every horizontal active window it writes a start-of-video code (SAV) ahead of the window and an end-of-video code (EAV) after it. Every other sample outside the window becomes the blanking fill pattern. Pixel values inside the window are clipped so that they can never look like the start of a code.

The vertical-blank flag and the field flag in each code come from the external vertical-active and field inputs. These inputs are latched at each line-start pulse, so every code carries the state of the line it belongs to. A mode input sets where the codes sit. In the standard 601-size interlaced mode, each code touches the window directly. In every other output size, two fill samples separate each code from the window edge.

The data path has a fixed delay of six clocks. This delay gives the block enough lookahead to start the SAV before the delayed window arrives, without any line counter.

Top module: `sync_code_inserter`

## Requirements
- R1: While reset is held, and after it is released until the pipeline fills, `pix_out` carries fill. During reset the value is 0x80.
- R2: A pixel presented with `win_valid`=1, on a line whose latched vertical state is active, appears on `pix_out` exactly 6 clocks later. Its value is unchanged unless R3 applies.
- R3: A window pixel of 0x00 is output as 0x01 and a window pixel of 0xFF is output as 0xFE. Outside a code, `pix_out` therefore never carries 0x00 or 0xFF.
- R4: An SAV is the four bytes 0xFF, 0x00, 0x00, XY with H=0. Its last byte sits G samples before the first output window sample.
- R5: An EAV is the same four-byte form with H=1. Its first byte sits G samples after the last output window sample.
- R6: The XY byte is {1, F, V, H, V^H, F^H, F^V, F^V^H}, with bit 7 first.
- R7: V is the inverse of `vert_active` and F is `field_id`, both sampled at the last `line_start` pulse before the window. Changes to these inputs between line-start pulses have no effect on the codes of that line.
- R8: Every output sample that is neither a code byte nor window data is fill. The fill is 0x80 on odd output cycles and 0x10 on even output cycles, counting the first clock edge after reset release as cycle 1.
- R9: On a line latched with `vert_active`=0, the window samples are replaced by fill. Both codes are still emitted, with V=1.
- R10: G is 0 when `fmt_std`=1 (standard size) and 2 when `fmt_std`=0. In the second case the two samples on each side between code and window are fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fmt_std | input | 1 | 1 = standard 601 interlaced size (codes touch the window), 0 = other sizes (2-sample gap) |
| line_start | input | 1 | One-cycle line-start pulse; latches vertical and field state |
| vert_active | input | 1 | Vertical active region flag |
| field_id | input | 1 | Field identifier |
| win_valid | input | 1 | Marks the horizontal active pixel window |
| pix_in | input | 8 | Multiplexed YCbCr input sample |
| pix_out | output | 8 | Stream with embedded timing codes, delayed by 6 clocks |

## Verification
The checker assumes three things about the inputs. A line-start pulse never falls inside the active window. `fmt_std` holds still while the window is open. Consecutive windows are far enough apart that no SAV, EAV or gap sample overlaps another line's code or window; this means at least 11 samples of blanking before each window and at least 12 after it. The stimulus is built line by line to respect these limits. Each line places its line-start pulse 8 samples before the window and leaves 14 samples after it. The mode input changes only on a line-start sample. Within each line, the vertical and field inputs are toggled after the pulse to show that only the latched value counts.

// File: rtl/sci_pkg.sv
package sci_pkg;
    localparam int DW = 8;

    // Per-sample timing tag carried down the delay line
    typedef struct packed {
        logic win;   // sample lies in the active window
        logic fld;   // latched field flag of its line
        logic vblk;  // latched vertical blank flag of its line
    } sci_tag_t;

    typedef enum logic [1:0] {
        SEL_FILL = 2'd0,
        SEL_DATA = 2'd1,
        SEL_SAV  = 2'd2,
        SEL_EAV  = 2'd3
    } sci_sel_e;

    // R6: status byte with protection bits
    function automatic logic [DW-1:0] sci_xy(input logic f, input logic v, input logic h);
        return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
    endfunction

    // R3: keep window data off the reserved code values
    function automatic logic [DW-1:0] sci_clip(input logic [DW-1:0] x);
        if (x == '0)
            return DW'(1);
        else if (x == '1)
            return {{(DW-1){1'b1}}, 1'b0};
        else
            return x;
    endfunction
endpackage

// File: rtl/sci_line_flags.sv
module sci_line_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic line_start,
    input  logic vert_active,
    input  logic field_id,
    output logic fld,
    output logic vblk
);
    typedef struct packed {
        logic fld;
        logic vblk;
    } lf_t;

    lf_t st_d, st_q;

    // R7: vertical/field state captured only at the line-start pulse
    always_comb begin
        st_d = st_q;
        if (line_start) begin
            st_d.fld  = field_id;
            st_d.vblk = ~vert_active;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.fld  <= 1'b0;
            st_q.vblk <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign fld  = st_q.fld;
    assign vblk = st_q.vblk;
endmodule

// File: rtl/sci_delay_line.sv
module sci_delay_line
    import sci_pkg::*;
#(
    parameter int LAT  = 6,
    parameter int NTAP = 13
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [DW-1:0]        pix_in,
    input  sci_tag_t             tag_in,
    output logic [DW-1:0]        pix_tail,
    output sci_tag_t [NTAP-1:0]  taps
);
    localparam int NREG = NTAP - 1;

    typedef struct packed {
        logic [LAT-1:0][DW-1:0] pix;
        sci_tag_t [NREG-1:0]    tag;
    } dl_t;

    dl_t st_d, st_q;

    always_comb begin
        st_d.pix[0] = pix_in;
        for (int j = 1; j < LAT; j++) begin
            st_d.pix[j] = st_q.pix[j-1];
        end
        st_d.tag[0] = tag_in;
        for (int j = 1; j < NREG; j++) begin
            st_d.tag[j] = st_q.tag[j-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pix_tail = st_q.pix[LAT-1];
    assign taps[0]  = tag_in;

    generate
        for (genvar t = 1; t < NTAP; t++) begin : g_tap
            assign taps[t] = st_q.tag[t-1];
        end
    endgenerate
endmodule

// File: rtl/sci_code_select.sv
module sci_code_select
    import sci_pkg::*;
#(
    parameter int LAT  = 6,
    parameter int GAP  = 2,
    parameter int NTAP = 13
) (
    input  sci_tag_t [NTAP-1:0] taps,
    input  logic                fmt_std,
    output sci_sel_e            sel,
    output logic [1:0]          idx,
    output logic                fld,
    output logic                vblk
);
    localparam int CODE_LEN = 4;

    always_comb begin
        int gap;
        sel  = SEL_FILL;
        idx  = 2'd0;
        fld  = 1'b0;
        vblk = 1'b0;
        gap  = fmt_std ? 0 : GAP;   // R10
        if (taps[LAT].win) begin
            // R2 / R9: window sample reaches the output
            if (!taps[LAT].vblk)
                sel = SEL_DATA;
        end else begin
            for (int i = 0; i < CODE_LEN; i++) begin
                // R5: window ended gap+i samples before this output slot
                if (!taps[LAT+gap+i].win && taps[LAT+gap+i+1].win) begin
                    sel  = SEL_EAV;
                    idx  = 2'(i);
                    fld  = taps[LAT+gap+i+1].fld;
                    vblk = taps[LAT+gap+i+1].vblk;
                end else if (taps[LAT-CODE_LEN-gap+i].win &&
                             !taps[LAT-CODE_LEN-gap+i+1].win) begin
                    // R4: window starts CODE_LEN+gap-i samples ahead
                    sel  = SEL_SAV;
                    idx  = 2'(i);
                    fld  = taps[LAT-CODE_LEN-gap+i].fld;
                    vblk = taps[LAT-CODE_LEN-gap+i].vblk;
                end
            end
        end
    end
endmodule

// File: rtl/sync_code_inserter.sv
module sync_code_inserter
    import sci_pkg::*;
#(
    parameter int LAT = 6,
    parameter int GAP = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fmt_std,
    input  logic          line_start,
    input  logic          vert_active,
    input  logic          field_id,
    input  logic          win_valid,
    input  logic [DW-1:0] pix_in,
    output logic [DW-1:0] pix_out
);
    // Taps reach back far enough to see the last window sample at the end of an EAV
    localparam int NTAP = LAT + GAP + 5;
    localparam logic [DW-1:0] FILL_A = 8'h80;
    localparam logic [DW-1:0] FILL_B = 8'h10;

    typedef struct packed {
        logic [DW-1:0] pix;
        logic          phase;
    } out_t;

    logic                lf_fld, lf_vblk;
    sci_tag_t            tag_in;
    sci_tag_t [NTAP-1:0] taps;
    logic [DW-1:0]       pix_tail;
    sci_sel_e            sel;
    logic [1:0]          idx;
    logic                c_fld, c_vblk;
    out_t                st_d, st_q;

    sci_line_flags u_flags (
        .clk         (clk),
        .rst_n       (rst_n),
        .line_start  (line_start),
        .vert_active (vert_active),
        .field_id    (field_id),
        .fld         (lf_fld),
        .vblk        (lf_vblk)
    );

    assign tag_in = {win_valid, lf_fld, lf_vblk};

    sci_delay_line #(.LAT(LAT), .NTAP(NTAP)) u_dly (
        .clk      (clk),
        .rst_n    (rst_n),
        .pix_in   (pix_in),
        .tag_in   (tag_in),
        .pix_tail (pix_tail),
        .taps     (taps)
    );

    sci_code_select #(.LAT(LAT), .GAP(GAP), .NTAP(NTAP)) u_sel (
        .taps    (taps),
        .fmt_std (fmt_std),
        .sel     (sel),
        .idx     (idx),
        .fld     (c_fld),
        .vblk    (c_vblk)
    );

    always_comb begin
        st_d.phase = ~st_q.phase;
        // R8: fill alternates per output cycle
        st_d.pix   = st_q.phase ? FILL_B : FILL_A;
        case (sel)
            SEL_DATA: st_d.pix = sci_clip(pix_tail);
            SEL_SAV, SEL_EAV: begin
                case (idx)
                    2'd0:    st_d.pix = '1;
                    2'd3:    st_d.pix = sci_xy(c_fld, c_vblk, sel == SEL_EAV);
                    default: st_d.pix = '0;
                endcase
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.pix   <= FILL_A;   // R1
            st_q.phase <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pix_out = st_q.pix;
endmodule

// File: rtl/sync_code_inserter_chk.sv
module sync_code_inserter_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       fmt_std,
    input logic       line_start,
    input logic       win_valid,
    input logic [7:0] pix_out
);
    logic seen_edge = 1'b0;

    always_ff @(posedge clk) seen_edge <= 1'b1;

    // R1: fill value while reset is held
    always @(negedge clk) begin
        if (seen_edge && !rst_n) begin
            assert_reset_fill_R1: assert (pix_out == 8'h80);
        end
    end

    // R4: a code start byte is always followed by a zero byte
    assert_ff_then_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pix_out == 8'hFF |=> pix_out == 8'h00);

    // R3: zero appears only inside a code preamble
    assert_zero_in_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pix_out == 8'h00 |-> ($past(pix_out) == 8'hFF || $past(pix_out) == 8'h00));

    // R6: status byte after a preamble carries consistent protection bits
    assert_xy_protect_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(pix_out, 3) == 8'hFF && $past(pix_out, 2) == 8'h00 && $past(pix_out, 1) == 8'h00)
        |-> (pix_out[7] &&
             pix_out[3] == (pix_out[5] ^ pix_out[4]) &&
             pix_out[2] == (pix_out[6] ^ pix_out[4]) &&
             pix_out[1] == (pix_out[6] ^ pix_out[5]) &&
             pix_out[0] == (pix_out[6] ^ pix_out[5] ^ pix_out[4])));

    // R10: input assumption - mode held while the window is open
    assert_mode_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid |-> $stable(fmt_std));

    // R7: input assumption - line start never inside the window
    assert_start_outside_R7: assert property (@(posedge clk) disable iff (!rst_n)
        line_start |-> !win_valid);
endmodule

bind sync_code_inserter sync_code_inserter_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .fmt_std    (fmt_std),
    .line_start (line_start),
    .win_valid  (win_valid),
    .pix_out    (pix_out)
);

// File: tb/sync_code_inserter_bench.sv
module sync_code_inserter_bench;
    localparam int LAT  = 6;
    localparam int GAP  = 2;
    localparam int MAXN = 4096;
    localparam int PRE  = 8;
    localparam int POST = 14;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       fmt_std, line_start, vert_active, field_id, win_valid;
    logic [7:0] pix_in;
    logic [7:0] pix_out;

    always #5 clk = ~clk;

    sync_code_inserter #(.LAT(LAT), .GAP(GAP)) u_sync_code_inserter (
        .clk         (clk),
        .rst_n       (rst_n),
        .fmt_std     (fmt_std),
        .line_start  (line_start),
        .vert_active (vert_active),
        .field_id    (field_id),
        .win_valid   (win_valid),
        .pix_in      (pix_in),
        .pix_out     (pix_out)
    );

    logic [7:0] s_pix [MAXN];
    logic       s_win [MAXN];
    logic       s_hd  [MAXN];
    logic       s_va  [MAXN];
    logic       s_fl  [MAXN];
    logic       s_std [MAXN];
    logic [7:0] e_pix [MAXN];
    string      e_tag [MAXN];

    int nsamp  = 0;
    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    function automatic logic [7:0] fill_at(input int n);
        return (n % 2 == 1) ? 8'h80 : 8'h10;
    endfunction

    function automatic logic [7:0] xy_of(input int f, input int v, input int h);
        logic fb, vb, hb;
        fb = (f != 0); vb = (v != 0); hb = (h != 0);
        return {1'b1, fb, vb, hb, vb ^ hb, fb ^ hb, fb ^ vb, fb ^ vb ^ hb};
    endfunction

    function automatic logic [7:0] clip_of(input logic [7:0] x);
        if (x == 8'h00) return 8'h01;
        if (x == 8'hFF) return 8'hFE;
        return x;
    endfunction

    task automatic add_line(input int std, input int va, input int fl, input int w, input int pat);
        int base, len, ws, we, g, vb;
        string xt;
        base = nsamp + 1;
        len  = PRE + w + POST;
        ws   = base + PRE;
        we   = ws + w;
        g    = (std != 0) ? 0 : GAP;
        vb   = (va != 0) ? 0 : 1;
        xt   = (vb != 0 || fl != 0) ? "R7" : "R6";
        for (int o = 0; o < len; o++) begin
            int s;
            s = base + o;
            s_hd[s]  = (o == 0);
            s_std[s] = (std != 0);
            // R7: after the pulse the vertical/field inputs flip and must be ignored
            s_va[s]  = (o == 0) ? (va != 0) : (va == 0);
            s_fl[s]  = (o == 0) ? (fl != 0) : (fl == 0);
            s_win[s] = (o >= PRE) && (o < PRE + w);
            if (s_win[s]) begin
                int j;
                j = o - PRE;
                if (pat == 0)
                    s_pix[s] = (j % 2 == 1) ? 8'hFF : 8'h00;
                else
                    s_pix[s] = 8'((j * 61 + w * 7 + 17) & 255);
                if (va != 0) begin
                    e_pix[s+LAT] = clip_of(s_pix[s]);
                    e_tag[s+LAT] = (s_pix[s] == 8'h00 || s_pix[s] == 8'hFF) ? "R3" : "R2";
                end else begin
                    e_pix[s+LAT] = fill_at(s + LAT);
                    e_tag[s+LAT] = "R9";
                end
            end else begin
                s_pix[s] = 8'((o * 29 + 3) & 255);
            end
        end
        for (int i = 0; i < 4; i++) begin
            int ns, ne;
            ns = ws - 4 - g + i + LAT;
            ne = we + g + i + LAT;
            e_pix[ns] = (i == 0) ? 8'hFF : (i == 3) ? xy_of(fl, vb, 0) : 8'h00;
            e_pix[ne] = (i == 0) ? 8'hFF : (i == 3) ? xy_of(fl, vb, 1) : 8'h00;
            e_tag[ns] = (i == 3) ? xt : (std != 0 && i == 0) ? "R10" : "R4";
            e_tag[ne] = (i == 3) ? xt : "R5";
        end
        if (g > 0) begin
            // R10: gap samples between codes and window carry fill
            for (int k = 0; k < g; k++) begin
                e_pix[ws-1-k+LAT] = fill_at(ws - 1 - k + LAT);
                e_tag[ws-1-k+LAT] = "R10";
                e_pix[we+k+LAT]   = fill_at(we + k + LAT);
                e_tag[we+k+LAT]   = "R10";
            end
        end
        nsamp = nsamp + len;
    endtask

    task automatic drive(input int n);
        line_start  = s_hd[n];
        vert_active = s_va[n];
        field_id    = s_fl[n];
        win_valid   = s_win[n];
        fmt_std     = s_std[n];
        pix_in      = s_pix[n];
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        int widths [5];
        widths = '{1, 2, 3, 5, 8};
        for (int n = 0; n < MAXN; n++) begin
            s_pix[n] = 8'h00; s_win[n] = 1'b0; s_hd[n] = 1'b0;
            s_va[n] = 1'b0; s_fl[n] = 1'b0; s_std[n] = 1'b0;
            e_pix[n] = fill_at(n);
            e_tag[n] = "R8";
        end
        nsamp = 10;
        for (int sd = 0; sd < 2; sd++)
            for (int va = 0; va < 2; va++)
                for (int fl = 0; fl < 2; fl++)
                    for (int wi = 0; wi < 5; wi++)
                        for (int pt = 0; pt < 2; pt++)
                            add_line(sd, va, fl, widths[wi], pt);
        nsamp = nsamp + 20;

        rst_n = 1'b0;
        line_start = 1'b0; vert_active = 1'b0; field_id = 1'b0;
        win_valid = 1'b0; fmt_std = 1'b0; pix_in = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if (pix_out !== 8'h80) begin
            fails++;
            $display("FAIL R1 reset value got %02h expected 80", pix_out);
        end
        rst_n = 1'b1;
        for (int n = 1; n <= nsamp; n++) begin
            drive(n);
            @(posedge clk);
            @(negedge clk);
            checks++;
            if (pix_out !== e_pix[n]) begin
                fails++;
                $display("FAIL %s cycle %0d got %02h expected %02h", e_tag[n], n, pix_out, e_pix[n]);
            end
        end
        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R2 watchdog expired got %0d checks expected %0d", checks, nsamp + 1);
            finish_run();
        end
    end
endmodule